// File: doc/BRIEF.md
# Flash Access Permission Guard

This block rules on every access that reaches the on-chip flash. A CPU access, read or write, and a read from the external debug port or an external programmer each get a verdict: allow or deny. The verdict comes from three inputs. The first is the area the address falls into. The second is a set of per-section write-enable bits that software controls. The third is a pair of 3-bit global protection fields, taken from the stored protection word and voted by majority.

Flash program memory is split into three areas. A boot area starts at address zero and has a size that software programs. It is never writable by the CPU. The code area runs from the end of the boot area up to 0x03FFFF. The data area spans 0x0E0000 to 0x0E1FFF. Program sections are 8 KiB and data sections are 512 bytes. Each section opens for CPU writes only when its enable bit is set and the global write lock is off. Every refused CPU write raises a one-cycle pulse and a sticky status flag.

Top module: `flash_guard`

## Requirements
- R1: After reset every write-enable bit, the boot boundary and the sticky status are 0. No allow, deny or violation output is high. Reading any register offset returns 0.
- R2: Register offset 3 holds the boot boundary, a byte address. The boot area is every address below it. A written value above 0x7800 is stored as 0x7800, so the last boot address is at most 0x77FF. Read-back returns the stored value.
- R3: A CPU write to an address below the boot boundary is denied, whatever the enable bits and the global fields hold. CPU reads of the boot area are allowed.
- R4: A CPU write in the code area (boundary to 0x03FFFF) is allowed only if the bit for section address[17:13] is set and the write lock is off. Sections 0-15 are bits 15:0 of register offset 0. Sections 16-31 are bits 15:0 of offset 1.
- R5: A CPU write in the data area (0x0E0000 to 0x0E1FFF) is allowed only if bit address[12:9] of register offset 2 is set and the write lock is off.
- R6: The global write lock is on when two or more of the three write-protect input bits are 0.
- R7: An external read is allowed only if its address is in one of the three areas and the read lock is off. The read lock is on when two or more of the three read-protect bits are 0. CPU reads of any of the three areas are allowed whatever the read lock holds.
- R8: Addresses outside the three areas are denied for CPU reads, CPU writes and external reads.
- R9: The verdict for a request is registered. It appears one cycle after the request is presented. For each request exactly one of allow and deny is high, and both stay low for a cycle with no request.
- R10: A denied CPU write raises the violation output for exactly one cycle, in the same cycle as its deny.
- R11: Bit 0 of register offset 4 is a sticky violation flag. A denied CPU write sets it and writing 1 clears it. If a set and a clear fall in the same cycle, the set wins. Offsets 5-7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| wp_bits | input | 3 | Stored global write-protect field |
| rp_bits | input | 3 | Stored global read-protect field |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 24 | CPU byte address |
| cpu_allow | output | 1 | CPU access permitted |
| cpu_deny | output | 1 | CPU access refused |
| viol_pulse | output | 1 | One-cycle pulse on a refused CPU write |
| ext_req | input | 1 | External debug/programmer read request |
| ext_addr | input | 24 | External read byte address |
| ext_allow | output | 1 | External read permitted |
| ext_deny | output | 1 | External read refused |

## Verification
The allow, deny and violation outputs for a request presented before a rising edge are due right after that edge. A register write or a sticky-flag set made at an edge shows on reg_rdata in the cycle that follows it. The bench drives all inputs on the falling edge and runs a behavioural reference one step ahead. It then samples every output on the next falling edge, one full edge after the stimulus, so it compares each result in exactly the cycle it is due. The protection fields are changed on the same falling edge as the request they should govern.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

   typedef enum logic [1:0] {
      AREA_NONE = 2'd0,
      AREA_BOOT = 2'd1,
      AREA_CODE = 2'd2,
      AREA_DATA = 2'd3
   } area_e;

endpackage

// File: rtl/fg_vote.sv
module fg_vote #(
   parameter int N = 3
) (
   input  logic [N-1:0] bits,
   output logic         locked
);
   generate
      if (N % 2 == 0) begin : g_bad_width
         $error("fg_vote: N must be odd");
      end
   endgenerate

   always_comb begin
      int zeros;
      zeros = 0;
      for (int i = 0; i < N; i++) begin
         if (!bits[i]) zeros++;
      end
      locked = (zeros > N / 2);
   end
endmodule

// File: rtl/fg_decode.sv
module fg_decode
   import flash_guard_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int BND_W      = 16,
   parameter int PROG_LAST  = 32'h03FFFF,
   parameter int DATA_FIRST = 32'h0E0000,
   parameter int DATA_LAST  = 32'h0E1FFF,
   parameter int PSEC_LSB   = 13,
   parameter int PSEC_W     = 5,
   parameter int DSEC_LSB   = 9,
   parameter int DSEC_W     = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BND_W-1:0]  bnd,
   output area_e             area,
   output logic [PSEC_W-1:0] psec,
   output logic [DSEC_W-1:0] dsec
);
   generate
      if (BND_W > ADDR_W) begin : g_bad_bnd
         $error("fg_decode: boundary wider than address");
      end
      if (PSEC_LSB + PSEC_W > ADDR_W || DSEC_LSB + DSEC_W > ADDR_W) begin : g_bad_sec
         $error("fg_decode: section field beyond address");
      end
   endgenerate

   logic [ADDR_W-1:0] bnd_ext;
   logic              in_boot, in_prog, in_data;

   assign bnd_ext = {{(ADDR_W-BND_W){1'b0}}, bnd};
   assign in_boot = (addr < bnd_ext);
   assign in_prog = (addr <= ADDR_W'(PROG_LAST));
   assign in_data = (addr >= ADDR_W'(DATA_FIRST)) && (addr <= ADDR_W'(DATA_LAST));
   assign psec    = addr[PSEC_LSB +: PSEC_W];
   assign dsec    = addr[DSEC_LSB +: DSEC_W];

   always_comb begin
      if (in_boot)      area = AREA_BOOT;
      else if (in_prog) area = AREA_CODE;
      else if (in_data) area = AREA_DATA;
      else              area = AREA_NONE;
   end
endmodule

// File: rtl/fg_regs.sv
module fg_regs #(
   parameter int          REG_W      = 16,
   parameter int          REG_AW     = 3,
   parameter int          PSEC_N     = 32,
   parameter int          DSEC_N     = 16,
   parameter logic [15:0] BOOT_LIMIT = 16'h7800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic              viol_set,
   output logic [PSEC_N-1:0] prog_en,
   output logic [DSEC_N-1:0] data_en,
   output logic [REG_W-1:0]  bnd
);
   localparam int PREG_N   = PSEC_N / REG_W;
   localparam int OFS_DATA = PREG_N;
   localparam int OFS_BND  = PREG_N + 1;
   localparam int OFS_STAT = PREG_N + 2;

   generate
      if (PSEC_N % REG_W != 0) begin : g_bad_psec
         $error("fg_regs: program sections must fill whole registers");
      end
      if (DSEC_N > REG_W) begin : g_bad_dsec
         $error("fg_regs: data sections exceed one register");
      end
      if (OFS_STAT >= (1 << REG_AW)) begin : g_bad_map
         $error("fg_regs: register map exceeds offset space");
      end
   endgenerate

   logic [PREG_N-1:0][REG_W-1:0] preg;
   logic [DSEC_N-1:0]            dreg;
   logic                         stat_q;

   genvar g;
   generate
      for (g = 0; g < PREG_N; g++) begin : g_preg
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= '0;
            else if (wr && addr == REG_AW'(g))   q <= wdata;
         end
         assign preg[g]                     = q;
         assign prog_en[g*REG_W +: REG_W]   = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dreg   <= '0;
         bnd    <= '0;
         stat_q <= 1'b0;
      end else begin
         if (wr && addr == REG_AW'(OFS_DATA)) dreg <= wdata[DSEC_N-1:0];
         if (wr && addr == REG_AW'(OFS_BND))
            bnd <= (wdata > BOOT_LIMIT) ? BOOT_LIMIT : wdata;
         if (viol_set)
            stat_q <= 1'b1;
         else if (wr && addr == REG_AW'(OFS_STAT) && wdata[0])
            stat_q <= 1'b0;
      end
   end

   assign data_en = dreg;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < PREG_N; i++) begin
         if (addr == REG_AW'(i)) rdata = preg[i];
      end
      if (addr == REG_AW'(OFS_DATA)) rdata = REG_W'(dreg);
      if (addr == REG_AW'(OFS_BND))  rdata = bnd;
      if (addr == REG_AW'(OFS_STAT)) rdata = REG_W'(stat_q);
   end

   p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bnd <= BOOT_LIMIT);
   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      viol_set |=> stat_q);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import flash_guard_pkg::*;
#(
   parameter int          ADDR_W     = 24,
   parameter int          REG_W      = 16,
   parameter int          REG_AW     = 3,
   parameter int          VOTE_W     = 3,
   parameter int          PROG_LAST  = 32'h03FFFF,
   parameter int          DATA_FIRST = 32'h0E0000,
   parameter int          DATA_LAST  = 32'h0E1FFF,
   parameter int          PSEC_LSB   = 13,
   parameter int          DSEC_LSB   = 9,
   parameter logic [15:0] BOOT_LIMIT = 16'h7800,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [VOTE_W-1:0] wp_bits,
   input  logic [VOTE_W-1:0] rp_bits,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_allow,
   output logic              cpu_deny,
   output logic              viol_pulse,
   input  logic              ext_req,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic              ext_allow,
   output logic              ext_deny
);
   localparam int PSEC_N = (PROG_LAST + 1) >> PSEC_LSB;
   localparam int PSEC_W = $clog2(PSEC_N);
   localparam int DSEC_N = (DATA_LAST - DATA_FIRST + 1) >> DSEC_LSB;
   localparam int DSEC_W = $clog2(DSEC_N);

   generate
      if ((PSEC_N << PSEC_LSB) != PROG_LAST + 1) begin : g_bad_prog
         $error("flash_guard: program area not a whole number of sections");
      end
      if ((DATA_FIRST % (1 << (DSEC_LSB + DSEC_W))) != 0) begin : g_bad_data
         $error("flash_guard: data area must be aligned to its size");
      end
   endgenerate

   logic [PSEC_N-1:0] prog_en;
   logic [DSEC_N-1:0] data_en;
   logic [REG_W-1:0]  bnd;
   logic              wlock, rlock;
   area_e             cpu_area, ext_area;
   logic [PSEC_W-1:0] cpu_psec, ext_psec;
   logic [DSEC_W-1:0] cpu_dsec, ext_dsec;
   logic              cpu_ok, ext_ok, viol_c;

   fg_vote #(.N(VOTE_W)) u_wvote (.bits(wp_bits), .locked(wlock));
   fg_vote #(.N(VOTE_W)) u_rvote (.bits(rp_bits), .locked(rlock));

   fg_decode #(
      .ADDR_W(ADDR_W), .BND_W(REG_W), .PROG_LAST(PROG_LAST),
      .DATA_FIRST(DATA_FIRST), .DATA_LAST(DATA_LAST),
      .PSEC_LSB(PSEC_LSB), .PSEC_W(PSEC_W), .DSEC_LSB(DSEC_LSB), .DSEC_W(DSEC_W)
   ) u_cpu_dec (.addr(cpu_addr), .bnd(bnd), .area(cpu_area), .psec(cpu_psec), .dsec(cpu_dsec));

   fg_decode #(
      .ADDR_W(ADDR_W), .BND_W(REG_W), .PROG_LAST(PROG_LAST),
      .DATA_FIRST(DATA_FIRST), .DATA_LAST(DATA_LAST),
      .PSEC_LSB(PSEC_LSB), .PSEC_W(PSEC_W), .DSEC_LSB(DSEC_LSB), .DSEC_W(DSEC_W)
   ) u_ext_dec (.addr(ext_addr), .bnd(bnd), .area(ext_area), .psec(ext_psec), .dsec(ext_dsec));

   fg_regs #(
      .REG_W(REG_W), .REG_AW(REG_AW), .PSEC_N(PSEC_N), .DSEC_N(DSEC_N),
      .BOOT_LIMIT(BOOT_LIMIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .viol_set(viol_c), .prog_en(prog_en), .data_en(data_en), .bnd(bnd)
   );

   always_comb begin
      unique case (cpu_area)
         AREA_BOOT: cpu_ok = !cpu_we;
         AREA_CODE: cpu_ok = !cpu_we || (prog_en[cpu_psec] && !wlock);
         AREA_DATA: cpu_ok = !cpu_we || (data_en[cpu_dsec] && !wlock);
         default:   cpu_ok = 1'b0;
      endcase
   end

   assign ext_ok = (ext_area != AREA_NONE) && !rlock;
   assign viol_c = cpu_req && cpu_we && !cpu_ok;

   generate
      if (OUT_REG) begin : g_flop_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cpu_allow  <= 1'b0;
               cpu_deny   <= 1'b0;
               viol_pulse <= 1'b0;
               ext_allow  <= 1'b0;
               ext_deny   <= 1'b0;
            end else begin
               cpu_allow  <= cpu_req && cpu_ok;
               cpu_deny   <= cpu_req && !cpu_ok;
               viol_pulse <= viol_c;
               ext_allow  <= ext_req && ext_ok;
               ext_deny   <= ext_req && !ext_ok;
            end
         end

         p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_req |=> !cpu_allow && !cpu_deny);
         p_boot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_req && cpu_we && cpu_area == AREA_BOOT) |=> cpu_deny);
         p_wlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_req && cpu_we && wlock) |=> !cpu_allow);
         p_rlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_req && rlock) |=> !ext_allow);
         p_cpurd_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_req && !cpu_we && cpu_area != AREA_NONE) |=> cpu_allow);
         p_unmap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_req && ext_area == AREA_NONE) |=> ext_deny);
      end else begin : g_comb_out
         assign cpu_allow  = cpu_req && cpu_ok;
         assign cpu_deny   = cpu_req && !cpu_ok;
         assign viol_pulse = viol_c;
         assign ext_allow  = ext_req && ext_ok;
         assign ext_deny   = ext_req && !ext_ok;
      end
   endgenerate

   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_allow && cpu_deny) && !(ext_allow && ext_deny));
   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> cpu_deny);
endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  wp_bits = 3'b111;
   logic [2:0]  rp_bits = 3'b111;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic        cpu_allow, cpu_deny, viol_pulse;
   logic        ext_req = 1'b0;
   logic [23:0] ext_addr = '0;
   logic        ext_allow, ext_deny;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [31:0] m_pen = '0;
   logic [15:0] m_den = '0;
   int          m_bnd = 0;
   bit          m_stat = 1'b0;

   always #2 clk = ~clk;

   flash_guard u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_bits(wp_bits), .rp_bits(rp_bits),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_allow(cpu_allow),
      .cpu_deny(cpu_deny), .viol_pulse(viol_pulse), .ext_req(ext_req), .ext_addr(ext_addr),
      .ext_allow(ext_allow), .ext_deny(ext_deny)
   );

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic bit lock3(logic [2:0] b);
      int z = 0;
      for (int i = 0; i < 3; i++) if (!b[i]) z++;
      return z >= 2;
   endfunction

   // 0 none, 1 boot, 2 code, 3 data
   function automatic int m_area(logic [23:0] a);
      int ai = int'(a);
      if (ai < m_bnd) return 1;
      if (ai <= 32'h3FFFF) return 2;
      if (ai >= 32'hE0000 && ai <= 32'hE1FFF) return 3;
      return 0;
   endfunction

   function automatic bit m_cpu_ok(logic [23:0] a, bit we);
      int ar = m_area(a);
      int ai = int'(a);
      if (ar == 0) return 1'b0;
      if (!we) return 1'b1;
      if (ar == 1) return 1'b0;
      if (lock3(wp_bits)) return 1'b0;
      if (ar == 2) return m_pen[(ai / 8192) % 32];
      return m_den[(ai / 512) % 16];
   endfunction

   function automatic logic [15:0] m_read(logic [2:0] ra);
      case (ra)
         3'd0: return m_pen[15:0];
         3'd1: return m_pen[31:16];
         3'd2: return m_den;
         3'd3: return 16'(m_bnd);
         3'd4: return {15'd0, m_stat};
         default: return 16'h0;
      endcase
   endfunction

   task automatic step(string tag, bit rwr, logic [2:0] ra, logic [15:0] rwd,
                       bit creq, bit cwe, logic [23:0] ca, bit ereq, logic [23:0] ea);
      bit ok, eok, e_ca, e_cd, e_v, e_ea, e_ed;
      logic [15:0] e_rd;
      reg_wr = rwr; reg_addr = ra; reg_wdata = rwd;
      cpu_req = creq; cpu_we = cwe; cpu_addr = ca;
      ext_req = ereq; ext_addr = ea;
      ok   = m_cpu_ok(ca, cwe);
      eok  = (m_area(ea) != 0) && !lock3(rp_bits);
      e_ca = creq && ok;
      e_cd = creq && !ok;
      e_v  = creq && cwe && !ok;
      e_ea = ereq && eok;
      e_ed = ereq && !eok;
      if (rwr) begin
         case (ra)
            3'd0: m_pen[15:0]  = rwd;
            3'd1: m_pen[31:16] = rwd;
            3'd2: m_den        = rwd;
            3'd3: m_bnd        = (int'(rwd) > 32'h7800) ? 32'h7800 : int'(rwd);
            3'd4: if (rwd[0]) m_stat = 1'b0;
            default: ;
         endcase
      end
      if (e_v) m_stat = 1'b1;
      e_rd = m_read(ra);
      @(posedge clk);
      @(negedge clk);
      chk(tag, "cpu_allow", 16'(cpu_allow), 16'(e_ca));
      chk(tag, "cpu_deny", 16'(cpu_deny), 16'(e_cd));
      chk(tag, "viol_pulse", 16'(viol_pulse), 16'(e_v));
      chk(tag, "ext_allow", 16'(ext_allow), 16'(e_ea));
      chk(tag, "ext_deny", 16'(ext_deny), 16'(e_ed));
      chk(tag, "reg_rdata", reg_rdata, e_rd);
   endtask

   task automatic wreg(string tag, logic [2:0] ra, logic [15:0] d);
      step(tag, 1'b1, ra, d, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0);
   endtask

   task automatic rreg(string tag, logic [2:0] ra);
      step(tag, 1'b0, ra, 16'h0, 1'b0, 1'b0, 24'h0, 1'b0, 24'h0);
   endtask

   task automatic cpu(string tag, bit we, logic [23:0] a, logic [2:0] ra);
      step(tag, 1'b0, ra, 16'h0, 1'b1, we, a, 1'b0, 24'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1", "cpu_allow", 16'(cpu_allow), 16'h0);
      chk("R1", "cpu_deny", 16'(cpu_deny), 16'h0);
      chk("R1", "viol_pulse", 16'(viol_pulse), 16'h0);
      chk("R1", "ext_allow", 16'(ext_allow | ext_deny), 16'h0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) rreg("R1", 3'(i));

      // R9: idle cycles, then a CPU read with write-enables off
      rreg("R9", 3'd0);
      cpu("R9", 1'b0, 24'h001000, 3'd4);

      // R2: boundary write and clamp
      wreg("R2", 3'd3, 16'h1234);
      rreg("R2", 3'd3);
      wreg("R2", 3'd3, 16'hFFFF);
      rreg("R2", 3'd3);
      wreg("R2", 3'd3, 16'h7801);
      wreg("R2", 3'd3, 16'h7800);

      // R3: boot area refuses writes even when fully enabled
      wreg("R3", 3'd0, 16'hFFFF);
      wreg("R3", 3'd1, 16'hFFFF);
      cpu("R3", 1'b1, 24'h000000, 3'd4);
      cpu("R3", 1'b1, 24'h0077FF, 3'd4);
      cpu("R3", 1'b1, 24'h007800, 3'd4);
      cpu("R3", 1'b0, 24'h000100, 3'd4);
      wreg("R11", 3'd4, 16'h0001);

      // R4: per-section code enables, lower and upper register
      wreg("R4", 3'd0, 16'h0010);
      wreg("R4", 3'd1, 16'h8001);
      cpu("R4", 1'b1, 24'h008000, 3'd0);
      cpu("R4", 1'b1, 24'h00A000, 3'd0);
      cpu("R4", 1'b1, 24'h020000, 3'd1);
      cpu("R4", 1'b1, 24'h03FFFF, 3'd1);
      cpu("R4", 1'b1, 24'h03C000, 3'd1);
      wreg("R11", 3'd4, 16'h0001);

      // R5: data-area sections
      wreg("R5", 3'd2, 16'h8002);
      cpu("R5", 1'b1, 24'h0E0200, 3'd2);
      cpu("R5", 1'b1, 24'h0E0000, 3'd2);
      cpu("R5", 1'b1, 24'h0E1FFF, 3'd2);
      cpu("R5", 1'b1, 24'h0E1C00, 3'd2);

      // R6: every write-protect pattern on an enabled section
      for (int p = 0; p < 8; p++) begin
         wp_bits = 3'(p);
         cpu("R6", 1'b1, 24'h008000, 3'd4);
         cpu("R6", 1'b1, 24'h0E0200, 3'd4);
      end
      wp_bits = 3'b111;

      // R7: every read-protect pattern, external and CPU reads together
      for (int p = 0; p < 8; p++) begin
         rp_bits = 3'(p);
         step("R7", 1'b0, 3'd0, 16'h0, 1'b1, 1'b0, 24'h0E0100, 1'b1, 24'h000100);
      end
      rp_bits = 3'b111;

      // R8: unmapped addresses
      step("R8", 1'b0, 3'd4, 16'h0, 1'b1, 1'b1, 24'h040000, 1'b1, 24'h040000);
      step("R8", 1'b0, 3'd4, 16'h0, 1'b1, 1'b0, 24'h0E2000, 1'b1, 24'h0DFFFF);
      step("R8", 1'b0, 3'd4, 16'h0, 1'b1, 1'b0, 24'hFFFFFF, 1'b1, 24'h0E1FFF);

      // R10/R11: pulse lasts one cycle, flag sticks, W1C, set beats clear
      cpu("R10", 1'b1, 24'h000010, 3'd4);
      rreg("R10", 3'd4);
      wreg("R11", 3'd4, 16'h0000);
      wreg("R11", 3'd4, 16'h0001);
      step("R11", 1'b1, 3'd4, 16'h0001, 1'b1, 1'b1, 24'h000020, 1'b0, 24'h0);
      rreg("R11", 3'd4);
      wreg("R11", 3'd4, 16'h0001);
      wreg("R11", 3'd5, 16'hFFFF);
      rreg("R11", 3'd7);

      // R2: shrink boot area to empty, address 0 becomes code section 0
      wreg("R2", 3'd3, 16'h0000);
      cpu("R2", 1'b1, 24'h000000, 3'd3);
      wreg("R2", 3'd0, 16'h0001);
      cpu("R2", 1'b1, 24'h000000, 3'd3);
      rreg("R9", 3'd3);

      finish_run();
   end
endmodule